// File: doc/BRIEF.md
# Adaptive Half-Bridge Dead-Time Controller

This block turns a one-bit switching-phase request into gate enables for the upper and lower switches of a half-bridge. When the request changes, the active switch is released at once. The opposite switch is enabled only after the slew of the bridge node is reported complete by an edge-detector flag. Two flags are used, one for each slew direction. A clamp of `DT_MAX` clock cycles bounds the wait. When the clamp expires, the opposite switch is forced on and a timeout event is raised.

Configuration straps choose the reaction to a timeout. The first choice rides through and raises no fault. The second latches the bridge off until the fault is cleared. The third holds the bridge off for `REC_CYCLES` cycles and then restarts by itself. An optional counter delays confirmation of a fault until `N_THRESH` timeouts have occurred with no valid slew flag between them. A fixed mode ignores both flags and uses `DT_MAX` as the ordinary dead time, with fault detection switched off.

All pins are plain level signals. No data stream passes through the block, so there is no valid/ready handshake and no back-pressure.

Top module: `adt_bridge_ctrl`

## Requirements
- R1: While `rst_n` is low, both driver enables, `dt_timeout` and `dt_fault` are 0. After reset is released, both enables stay off. The side selected by `phase_req` (1 = upper, 0 = lower) turns on at the `DT_MAX`-th rising edge after the release.
- R2: `drv_hi` and `drv_lo` are never 1 together. On the first rising edge where `phase_req` differs from the active side, that side's enable drops. The opposite enable is 0 in that same cycle.
- R3: Toward the lower side, only a rising edge of `sw_fall_done` ends the dead interval. Toward the upper side, only a rising edge of `sw_rise_done` does. The new side turns on at the edge that samples the flag high, so the gap equals the number of cycles until the flag rises. A flag for the other direction has no effect.
- R4: A flag that is already high when the dead interval starts does not end it.
- R5: If no valid flag edge arrives, the dead interval lasts exactly `DT_MAX` cycles. At its end `dt_timeout` pulses for one cycle. A flag edge sampled on the last cycle still counts as valid, and no timeout is raised.
- R6: With `fault_policy` = 2'b00, a timeout forces the opposite side on and `dt_fault` stays 0.
- R7: With `count_en` = 1, a fault is confirmed only on the `N_THRESH`-th counted timeout. Earlier timeouts force the opposite side on. With `count_en` = 0, the first timeout under a fault-raising policy is confirmed.
- R8: A dead interval that ends on a valid flag edge resets the timeout count to zero.
- R9: With `fault_policy` = 2'b01, a confirmed fault sets `dt_fault` and holds both enables off until `fault_clr` is sampled high. The restart then turns on the requested side `DT_MAX` cycles later.
- R10: With `fault_policy[1]` = 1, a confirmed fault sets `dt_fault` and holds both enables off for `REC_CYCLES` cycles. The block then restarts as in R9 without `fault_clr`.
- R11: With `fixed_mode` = 1, both flags are ignored. Every dead interval is `DT_MAX` cycles, `dt_timeout` stays 0 and no fault is raised.
- R12: `dt_fault` stays 1 until `fault_clr` is sampled high, including across an automatic restart. `fault_clr` also clears the timeout count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| phase_req | input | 1 | Requested conducting side: 1 upper, 0 lower |
| sw_fall_done | input | 1 | Upper-to-lower slew complete flag |
| sw_rise_done | input | 1 | Lower-to-upper slew complete flag |
| fixed_mode | input | 1 | Strap: fixed dead time, flags ignored |
| fault_policy | input | 2 | Strap: 00 ride through, 01 latch off, 1x auto-restart |
| count_en | input | 1 | Strap: require `N_THRESH` timeouts to confirm a fault |
| fault_clr | input | 1 | Clears `dt_fault`, the timeout count and a latched stop |
| drv_hi | output | 1 | Upper switch enable |
| drv_lo | output | 1 | Lower switch enable |
| dt_timeout | output | 1 | One-cycle pulse when the dead-time clamp expires |
| dt_fault | output | 1 | Confirmed dead-time fault, held until cleared |

## Verification
The handover is driven with the correct flag at several delays, including a delay of one cycle and a delay that lands on the last cycle of the clamp. It is also driven with the flag for the wrong direction, with a flag held high from before the interval, and with no flag at all. Together these separate an edge-triggered, direction-matched release from a level-triggered one or a crossed one. They also separate an off-by-one clamp from a correct one. A sequence of timeouts broken by one valid handover tells a counter that resets on success from one that only accumulates. The latch and auto-restart stops are told apart by whether the drivers come back without `fault_clr`, and by how long they stay off.

// File: rtl/adt_pkg.sv
package adt_pkg;

  typedef enum logic [2:0] {
    ST_START = 3'd0,
    ST_ON_HI = 3'd1,
    ST_ON_LO = 3'd2,
    ST_DEAD  = 3'd3,
    ST_HALT  = 3'd4
  } adt_state_e;

  typedef enum logic [1:0] {
    POL_RIDE   = 2'b00,
    POL_LATCH  = 2'b01,
    POL_RETRY  = 2'b10,
    POL_RETRY2 = 2'b11
  } adt_policy_e;

  // Index of each slew flag inside the flag vector.
  localparam int FLAG_TO_LO = 0;
  localparam int FLAG_TO_HI = 1;
  localparam int NUM_FLAGS  = 2;

  function automatic logic policy_raises(input adt_policy_e p);
    return p != POL_RIDE;
  endfunction

  function automatic logic policy_retries(input adt_policy_e p);
    return (p == POL_RETRY) || (p == POL_RETRY2);
  endfunction

endpackage

// File: rtl/adt_edge_sense.sv
module adt_edge_sense #(
  parameter int NUM = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NUM-1:0] level,
  output logic [NUM-1:0] rise
);

  for (genvar g = 0; g < NUM; g++) begin : g_bit
    logic prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= level[g];
    end

    assign rise[g] = level[g] & ~prev_q;

    // A reported edge must come from a low level in the previous cycle
    AST_RISE_NEEDS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      rise[g] |-> !$past(level[g])); // R4
  end

endmodule

// File: rtl/adt_fault_policy.sv
module adt_fault_policy
  import adt_pkg::*;
#(
  parameter int N_THRESH = 3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  adt_policy_e policy,
  input  logic        count_en,
  input  logic        fault_clr,
  input  logic        timeout_ev,
  input  logic        valid_end,
  output logic        halt_now,
  output logic        dt_fault
);

  localparam int CW = (N_THRESH < 2) ? 1 : $clog2(N_THRESH + 1);
  localparam logic [CW-1:0] LAST_CNT = CW'(N_THRESH - 1);

  logic [CW-1:0] cnt_q;
  logic          fault_q;
  logic          raises;
  logic          confirm;

  assign raises   = policy_raises(policy);
  assign confirm  = !count_en || (cnt_q >= LAST_CNT);
  assign halt_now = timeout_ev && raises && confirm;
  assign dt_fault = fault_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      fault_q <= 1'b0;
    end else if (fault_clr) begin
      cnt_q   <= '0;
      fault_q <= 1'b0;
    end else if (valid_end) begin
      cnt_q   <= '0;
    end else if (timeout_ev && raises) begin
      if (confirm) begin
        cnt_q   <= '0;
        fault_q <= 1'b1;
      end else begin
        cnt_q   <= cnt_q + CW'(1);
      end
    end
  end

  AST_FAULT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    $past(fault_q) && !$past(fault_clr) |-> fault_q); // R12

  AST_RIDE_NO_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    $past(policy == POL_RIDE) && !$past(fault_q) |-> !fault_q); // R6

  AST_COUNT_BELOW_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < CW'(N_THRESH)); // R7

  AST_SUCCESS_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    $past(valid_end) |-> cnt_q == '0); // R8

endmodule

// File: rtl/adt_phase_fsm.sv
module adt_phase_fsm
  import adt_pkg::*;
#(
  parameter int DT_MAX     = 16,
  parameter int REC_CYCLES = 40
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 phase_req,
  input  logic                 fixed_mode,
  input  logic                 auto_mode,
  input  logic                 fault_clr,
  input  logic [NUM_FLAGS-1:0] rise,
  input  logic                 halt_now,
  output logic                 timeout_ev,
  output logic                 valid_end,
  output logic                 drv_hi,
  output logic                 drv_lo,
  output logic                 dt_timeout
);

  localparam int TW = $clog2(DT_MAX + 1);
  localparam int RW = $clog2(REC_CYCLES + 1);
  localparam logic [TW-1:0] T_LAST = TW'(DT_MAX - 1);
  localparam logic [RW-1:0] R_LAST = RW'(REC_CYCLES - 1);

  adt_state_e    st_q, st_d;
  logic [TW-1:0] tmr_q, tmr_d;
  logic [RW-1:0] rec_q, rec_d;
  logic          tgt_q, tgt_d;    // 1: next side is upper
  logic          hi_q, lo_q, to_q;
  logic          tmr_last;
  logic          exp_rise;
  logic          expire;

  assign tmr_last   = (tmr_q == T_LAST);
  assign exp_rise   = tgt_q ? rise[FLAG_TO_HI] : rise[FLAG_TO_LO];
  assign valid_end  = (st_q == ST_DEAD) && !fixed_mode && exp_rise;
  assign expire     = (st_q == ST_DEAD) && tmr_last && !valid_end;
  assign timeout_ev = expire && !fixed_mode;

  always_comb begin
    st_d  = st_q;
    tmr_d = tmr_q;
    rec_d = rec_q;
    tgt_d = tgt_q;
    unique case (st_q)
      ST_START: begin
        if (tmr_last) begin
          st_d  = phase_req ? ST_ON_HI : ST_ON_LO;
          tmr_d = '0;
        end else begin
          tmr_d = tmr_q + TW'(1);
        end
      end
      ST_ON_HI: begin
        if (!phase_req) begin
          st_d  = ST_DEAD;
          tgt_d = 1'b0;
          tmr_d = '0;
        end
      end
      ST_ON_LO: begin
        if (phase_req) begin
          st_d  = ST_DEAD;
          tgt_d = 1'b1;
          tmr_d = '0;
        end
      end
      ST_DEAD: begin
        if (valid_end || (expire && !halt_now)) begin
          st_d  = tgt_q ? ST_ON_HI : ST_ON_LO;
          tmr_d = '0;
        end else if (expire) begin
          st_d  = ST_HALT;
          rec_d = '0;
          tmr_d = '0;
        end else begin
          tmr_d = tmr_q + TW'(1);
        end
      end
      ST_HALT: begin
        if (fault_clr || (auto_mode && rec_q == R_LAST)) begin
          st_d  = ST_START;
          tmr_d = '0;
        end else if (auto_mode) begin
          rec_d = rec_q + RW'(1);
        end
      end
      default: begin
        st_d  = ST_START;
        tmr_d = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_START;
      tmr_q <= '0;
      rec_q <= '0;
      tgt_q <= 1'b0;
      hi_q  <= 1'b0;
      lo_q  <= 1'b0;
      to_q  <= 1'b0;
    end else begin
      st_q  <= st_d;
      tmr_q <= tmr_d;
      rec_q <= rec_d;
      tgt_q <= tgt_d;
      hi_q  <= (st_d == ST_ON_HI);
      lo_q  <= (st_d == ST_ON_LO);
      to_q  <= timeout_ev;
    end
  end

  assign drv_hi     = hi_q;
  assign drv_lo     = lo_q;
  assign dt_timeout = to_q;

  AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
    !(hi_q && lo_q)); // R2

  AST_HI_BREAK_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    $past(hi_q) |-> !lo_q); // R2

  AST_LO_BREAK_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    $past(lo_q) |-> !hi_q); // R2

  AST_FIXED_NO_TIMEOUT: assert property (@(posedge clk) disable iff (!rst_n)
    $past(fixed_mode) |-> !to_q); // R11

  AST_HALT_DRIVERS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_HALT) |-> (!hi_q && !lo_q)); // R9

  AST_TIMEOUT_ENDS_DEAD: assert property (@(posedge clk) disable iff (!rst_n)
    to_q |-> st_q != ST_DEAD); // R5

endmodule

// File: rtl/adt_bridge_ctrl.sv
module adt_bridge_ctrl
  import adt_pkg::*;
#(
  parameter int DT_MAX     = 16,
  parameter int N_THRESH   = 3,
  parameter int REC_CYCLES = 40
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       phase_req,
  input  logic       sw_fall_done,
  input  logic       sw_rise_done,
  input  logic       fixed_mode,
  input  logic [1:0] fault_policy,
  input  logic       count_en,
  input  logic       fault_clr,
  output logic       drv_hi,
  output logic       drv_lo,
  output logic       dt_timeout,
  output logic       dt_fault
);

  adt_policy_e          pol;
  logic [NUM_FLAGS-1:0] flags;
  logic [NUM_FLAGS-1:0] rise;
  logic                 timeout_ev;
  logic                 valid_end;
  logic                 halt_now;

  assign pol               = adt_policy_e'(fault_policy);
  assign flags[FLAG_TO_LO] = sw_fall_done;
  assign flags[FLAG_TO_HI] = sw_rise_done;

  adt_edge_sense #(.NUM(NUM_FLAGS)) u_edges (
    .clk   (clk),
    .rst_n (rst_n),
    .level (flags),
    .rise  (rise)
  );

  adt_fault_policy #(.N_THRESH(N_THRESH)) u_policy (
    .clk        (clk),
    .rst_n      (rst_n),
    .policy     (pol),
    .count_en   (count_en),
    .fault_clr  (fault_clr),
    .timeout_ev (timeout_ev),
    .valid_end  (valid_end),
    .halt_now   (halt_now),
    .dt_fault   (dt_fault)
  );

  adt_phase_fsm #(.DT_MAX(DT_MAX), .REC_CYCLES(REC_CYCLES)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .phase_req  (phase_req),
    .fixed_mode (fixed_mode),
    .auto_mode  (policy_retries(pol)),
    .fault_clr  (fault_clr),
    .rise       (rise),
    .halt_now   (halt_now),
    .timeout_ev (timeout_ev),
    .valid_end  (valid_end),
    .drv_hi     (drv_hi),
    .drv_lo     (drv_lo),
    .dt_timeout (dt_timeout)
  );

  AST_FAULT_ONLY_AFTER_TIMEOUT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dt_fault) |-> dt_timeout); // R7

endmodule

// File: tb/test_adt_bridge_ctrl.sv
module test_adt_bridge_ctrl;

  localparam int DT_MAX = 16;
  localparam int N_THRESH = 3;
  localparam int REC_CYCLES = 40;

  typedef struct packed {
    logic       ph;
    logic [1:0] mode;   // 0 none, 1 matching flag, 2 wrong flag, 3 flag held high
    logic [7:0] dly;
    logic [7:0] gap;
    logic       to;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 2'd1, 8'd3,  8'd3,  1'b0},
    '{1'b1, 2'd1, 8'd1,  8'd1,  1'b0},
    '{1'b0, 2'd0, 8'd0,  8'd16, 1'b1},
    '{1'b1, 2'd2, 8'd4,  8'd16, 1'b1},
    '{1'b0, 2'd3, 8'd0,  8'd16, 1'b1},
    '{1'b1, 2'd1, 8'd16, 8'd16, 1'b0},
    '{1'b0, 2'd1, 8'd17, 8'd16, 1'b1},
    '{1'b1, 2'd1, 8'd8,  8'd8,  1'b0}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       phase_req = 1'b1;
  logic       sw_fall_done = 1'b0;
  logic       sw_rise_done = 1'b0;
  logic       fixed_mode = 1'b0;
  logic [1:0] fault_policy = 2'b00;
  logic       count_en = 1'b0;
  logic       fault_clr = 1'b0;
  logic       drv_hi, drv_lo, dt_timeout, dt_fault;

  int n_chk = 0;
  int n_fail = 0;
  int r_gap;
  bit r_to, r_both, r_oldoff, r_on;

  always #2 clk = ~clk;

  adt_bridge_ctrl #(.DT_MAX(DT_MAX), .N_THRESH(N_THRESH), .REC_CYCLES(REC_CYCLES)) i_adt_bridge_ctrl (
    .clk(clk), .rst_n(rst_n), .phase_req(phase_req),
    .sw_fall_done(sw_fall_done), .sw_rise_done(sw_rise_done),
    .fixed_mode(fixed_mode), .fault_policy(fault_policy), .count_en(count_en),
    .fault_clr(fault_clr), .drv_hi(drv_hi), .drv_lo(drv_lo),
    .dt_timeout(dt_timeout), .dt_fault(dt_fault)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic set_flag(input logic to_hi, input logic v);
    if (to_hi) sw_rise_done = v;
    else       sw_fall_done = v;
  endtask

  // Request a new side and measure the off gap seen at falling edges.
  task automatic do_switch(input logic ph, input int mode, input int dly);
    r_gap = 0; r_to = 0; r_both = 0; r_oldoff = 1; r_on = 0;
    @(negedge clk);
    phase_req = ph;
    if (mode == 3) set_flag(ph, 1'b1);
    for (int i = 1; i <= DT_MAX + 8; i++) begin
      @(negedge clk);
      if (drv_hi && drv_lo) r_both = 1;
      if (i == 1 && (ph ? drv_lo : drv_hi)) r_oldoff = 0;
      if (dt_timeout) r_to = 1;
      if (ph ? drv_hi : drv_lo) begin r_on = 1; break; end
      if (r_to && dt_fault) break;
      r_gap++;
      if (i == dly && mode == 1) set_flag(ph, 1'b1);
      if (i == dly && mode == 2) set_flag(!ph, 1'b1);
    end
    sw_fall_done = 1'b0;
    sw_rise_done = 1'b0;
  endtask

  // Count falling edges (including the current one) with both drivers off.
  task automatic count_off(output int n);
    n = 0;
    while (!(drv_hi || drv_lo) && n < 1000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic pulse_clear;
    @(negedge clk); fault_clr = 1'b1;
    @(negedge clk); fault_clr = 1'b0;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin : main
    int n;
    int bad;
    string tag;
    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1 reset drv_hi", drv_hi, 0);
    check("R1 reset drv_lo", drv_lo, 0);
    check("R1 reset dt_fault", dt_fault, 0);
    check("R1 reset dt_timeout", dt_timeout, 0);
    rst_n = 1'b1;
    count_off(n);
    check("R1 startup gap", n, DT_MAX);
    check("R1 startup side upper", drv_hi, 1);

    // Table of handovers under the ride-through policy
    for (int v = 0; v < NV; v++) begin
      do_switch(VECS[v].ph, int'(VECS[v].mode), int'(VECS[v].dly));
      case (VECS[v].mode)
        2'd0:    tag = "R5";
        2'd3:    tag = "R4";
        default: tag = (VECS[v].to) ? "R5" : "R3";
      endcase
      check($sformatf("%s vec%0d gap", tag, v), r_gap, int'(VECS[v].gap));
      check($sformatf("%s vec%0d timeout", tag, v), int'(r_to), int'(VECS[v].to));
      check($sformatf("R2 vec%0d old side off", v), int'(r_oldoff), 1);
      check($sformatf("R2 vec%0d overlap", v), int'(r_both), 0);
      check($sformatf("R6 vec%0d on and no fault", v), int'(r_on && !dt_fault), 1);
    end

    // Counting with latch policy
    @(negedge clk); fault_policy = 2'b01; count_en = 1'b1;
    do_switch(1'b0, 0, 0);
    check("R7 first timeout forced on", int'(r_on && r_to), 1);
    check("R7 first timeout no fault", dt_fault, 0);
    do_switch(1'b1, 1, 2);
    check("R8 valid handover gap", r_gap, 2);
    do_switch(1'b0, 0, 0);
    do_switch(1'b1, 0, 0);
    check("R8 count restarted, no fault yet", int'(r_on && !dt_fault), 1);
    do_switch(1'b0, 0, 0);
    check("R7 third timeout confirms", dt_fault, 1);
    check("R9 halted, lower off", int'(r_on), 0);
    check("R5 halt gap", r_gap, DT_MAX);
    bad = 0;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (drv_hi || drv_lo || !dt_fault) bad++;
    end
    check("R9 latched off held", bad, 0);
    pulse_clear();
    check("R12 clear drops fault", dt_fault, 0);
    count_off(n);
    check("R9 restart gap", n, DT_MAX);
    check("R9 restart side lower", drv_lo, 1);

    // Auto-restart, single timeout confirms
    @(negedge clk); fault_policy = 2'b10; count_en = 1'b0;
    do_switch(1'b1, 0, 0);
    check("R7 uncounted first timeout confirms", dt_fault, 1);
    count_off(n);
    check("R10 auto restart off time", n, REC_CYCLES + DT_MAX);
    check("R10 restart side upper", drv_hi, 1);
    check("R12 fault held across restart", dt_fault, 1);
    pulse_clear();
    check("R12 clear while running", dt_fault, 0);
    check("R12 clear leaves driver on", drv_hi, 1);

    // Fixed dead time
    @(negedge clk); fixed_mode = 1'b1; fault_policy = 2'b01;
    do_switch(1'b0, 1, 3);
    check("R11 fixed gap ignores flag", r_gap, DT_MAX);
    check("R11 fixed no timeout", int'(r_to), 0);
    do_switch(1'b1, 3, 0);
    check("R11 fixed gap held flag", r_gap, DT_MAX);
    check("R11 fixed no fault", int'(dt_fault || r_to), 0);

    // Reset mid-run
    @(negedge clk); fixed_mode = 1'b0; phase_req = 1'b0; rst_n = 1'b0;
    #1;
    check("R1 async reset drivers off", int'(drv_hi || drv_lo), 0);
    @(negedge clk); rst_n = 1'b1;
    count_off(n);
    check("R1 restart after reset gap", n, DT_MAX);
    check("R1 restart side lower", drv_lo, 1);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule